// File: doc/BRIEF.md
# Serial Frame Sender for a Quad 12-bit DAC

This block is the host-side driver of a four-channel 12-bit voltage DAC that has a three-wire serial input. A host presents a 2-bit channel number and a 12-bit code, then pulses `start`. The block pulls the active-low select line down and shifts out a 16-bit word, most significant bit first. The word holds the channel in its top two bits, two zero pad bits, and the code in the low twelve bits. Data changes only on falling edges of the serial clock. The serial clock is parked high whenever select moves, so the converter's internal OR of select and clock never sees a spurious rising edge.

After select goes high again, the block waits for a load delay and then drives an active-low load strobe that moves the word into the addressed DAC register. The strobe is issued automatically when `auto_load` is set. Otherwise it waits for `load_req`. A separate `clear_req` first drives the clear-level line (zero scale or midscale) and then, one delay period later, pulses the active-low clear strobe. `byte_mode` sends the frame as two 8-bit halves with the clock parked high between them and select kept low throughout, which is how a narrow host port would send it.

All timing is counted in system clock cycles. The divider, the select guard and the strobe widths are derived from nanosecond minimums and the system clock period, and each is rounded up. `busy` covers the whole operation, and `done` is a one-cycle pulse at its end.

Top module: `dacq_frame_tx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the block drives `ser_clk`=1, `sel_n`=1, `load_n`=1, `clr_n`=1, `clr_level`=0, `busy`=0 and `done`=0.
- R2: Each accepted `start` produces exactly 16 rising serial-clock edges while `sel_n` is low. The bits taken on those edges, first to last, form {chan_addr[1:0], 2'b00, code[11:0]}.
- R3: While `sel_n` stays low, `ser_dat` changes only in the cycle in which `ser_clk` falls. It therefore holds steady across every rising edge.
- R4: Whenever `sel_n` changes level, `ser_clk` is high both in that cycle and in the one before it.
- R5: The serial clock stays high for at least 13 ns and low for at least 13 ns. Rising edges are at least one 30 MHz period apart. Select falls at least 13 ns before the first clock fall and rises at least 13 ns after the last rising edge.
- R6: With `byte_mode`=1 the frame is still one select-low period. Between the 8th rising edge and the following fall, the clock stays high for the normal high phase plus at least `GAP_CYC` further cycles.
- R7: With `auto_load`=1, `load_n` goes low only after `sel_n` has been high for at least 20 ns, and it stays low for at least 20 ns, once per frame.
- R8: With `auto_load`=0, `load_n` stays high and `busy` stays high after the frame until `load_req` is pulsed. The load strobe then follows as in R7.
- R9: A `clear_req` from idle sets `clr_level` to `clear_to_mid` (1 = midscale, 0 = zero scale) at least 20 ns before `clr_n` falls. `clr_level` is held steady while `clr_n` is low for at least 20 ns. No frame and no load strobe occur.
- R10: `busy` rises in the cycle after an accepted `start` or `clear_req` and stays high through the strobe. `done` is a single-cycle pulse, issued with `busy`, `load_n` and `clr_n` already back to idle.
- R11: `start`, `clear_req` and `load_req` given while the block is busy with a frame are ignored. `load_n` and `sel_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a frame |
| chan_addr | input | 2 | DAC channel number sampled at start |
| code | input | 12 | DAC code sampled at start |
| byte_mode | input | 1 | Send frame as two 8-bit halves under one select |
| auto_load | input | 1 | Issue the load strobe automatically after the frame |
| load_req | input | 1 | Request the load strobe when waiting for it |
| clear_req | input | 1 | One-cycle request for a clear strobe |
| clear_to_mid | input | 1 | Clear target: 1 midscale, 0 zero scale |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dat | output | 1 | Serial data, changes on clock falls |
| sel_n | output | 1 | Active-low select |
| load_n | output | 1 | Active-low load strobe |
| clr_n | output | 1 | Active-low clear strobe |
| clr_level | output | 1 | Clear target level line |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench watches the lines the way the converter would. It rebuilds each word from the bits taken on rising edges and measures every high, low, guard and strobe run in cycles. A sender that moved data on the rising edge, or dropped the clock before select rose, would corrupt the captured word or trip the edge-parking rule. A divider with the wrong rounding would show phases shorter than 13 ns. The split-byte case looks for the long parked-high phase after bit 8 under a single select period, which a sender that ignored the mode would lack. Other directed cases cover a request made mid-frame, a load that must wait for its request, and clears at both levels. These catch strobes that overlap a frame, a clear level that is set late, and a `done` pulse that comes early or repeats.

// File: rtl/dacq_tx_pkg.sv
package dacq_tx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_HOLD,
    ST_WAIT_UPD,
    ST_LD_DLY,
    ST_LD_PULSE,
    ST_CLR_SET,
    ST_CLR_PULSE
  } tx_state_t;

  // integer division rounded up, for turning ns minimums into cycles
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacq_span_timer.sv
// Down-counter that measures one phase: load with N, expired after N cycles.
module dacq_span_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] span,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= span - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/dacq_frame_shreg.sv
// Parallel-load shift register presenting the next bit to send on msb.
module dacq_frame_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] frame,
  input  logic         shift,
  output logic         msb
);

  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (load) begin
      sr <= frame;
    end else if (shift) begin
      sr <= {sr[W-2:0], 1'b0};
    end
  end

  assign msb = sr[W-1];

endmodule

// File: rtl/dacq_tx_seq.sv
// Phase sequencer: frame shifting, load strobe and clear strobe.
// Outputs are registered from the next state so they line up with it.
module dacq_tx_seq
  import dacq_tx_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int HALF_CYC = 3,
  parameter int SEL_CYC  = 2,
  parameter int STB_CYC  = 3,
  parameter int GAP_LEN  = 4,
  parameter int TMR_W    = 3,
  parameter int BIT_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             byte_mode,
  input  logic             auto_load,
  input  logic             load_req,
  input  logic             clear_req,
  input  logic             clear_to_mid,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_span,
  output logic             shr_load,
  output logic             shr_shift,
  input  logic             shr_msb,
  output logic             ser_clk,
  output logic             ser_dat,
  output logic             sel_n,
  output logic             load_n,
  output logic             clr_n,
  output logic             clr_level,
  output logic             busy,
  output logic             done
);

  localparam int SPLIT_AT = FRAME_W / 2;
  localparam logic [TMR_W-1:0] HALF_T = TMR_W'(HALF_CYC);
  localparam logic [TMR_W-1:0] SEL_T  = TMR_W'(SEL_CYC);
  localparam logic [TMR_W-1:0] STB_T  = TMR_W'(STB_CYC);
  localparam logic [TMR_W-1:0] GAP_T  = TMR_W'(GAP_LEN);

  tx_state_t        st, nxt;
  logic [BIT_W-1:0] bits_left;
  logic             byte_q, auto_q;
  logic             take_clear;

  always_comb begin
    nxt        = st;
    tmr_load   = 1'b0;
    tmr_span   = '0;
    shr_load   = 1'b0;
    shr_shift  = 1'b0;
    take_clear = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          nxt      = ST_SETUP;
          tmr_load = 1'b1;
          tmr_span = SEL_T;
          shr_load = 1'b1;
        end else if (clear_req) begin
          nxt        = ST_CLR_SET;
          tmr_load   = 1'b1;
          tmr_span   = STB_T;
          take_clear = 1'b1;
        end
      end
      ST_SETUP, ST_GAP: begin
        if (tmr_expired) begin
          nxt       = ST_LOW;
          tmr_load  = 1'b1;
          tmr_span  = HALF_T;
          shr_shift = 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_expired) begin
          nxt      = ST_HIGH;
          tmr_load = 1'b1;
          tmr_span = HALF_T;
        end
      end
      ST_HIGH: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (bits_left == '0) begin
            nxt      = ST_HOLD;
            tmr_span = SEL_T;
          end else if (byte_q && (bits_left == BIT_W'(SPLIT_AT))) begin
            nxt      = ST_GAP;
            tmr_span = GAP_T;
          end else begin
            nxt       = ST_LOW;
            tmr_span  = HALF_T;
            shr_shift = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_expired) begin
          if (auto_q) begin
            nxt      = ST_LD_DLY;
            tmr_load = 1'b1;
            tmr_span = STB_T;
          end else begin
            nxt = ST_WAIT_UPD;
          end
        end
      end
      ST_WAIT_UPD: begin
        if (load_req) begin
          nxt      = ST_LD_DLY;
          tmr_load = 1'b1;
          tmr_span = STB_T;
        end
      end
      ST_LD_DLY: begin
        if (tmr_expired) begin
          nxt      = ST_LD_PULSE;
          tmr_load = 1'b1;
          tmr_span = STB_T;
        end
      end
      ST_CLR_SET: begin
        if (tmr_expired) begin
          nxt      = ST_CLR_PULSE;
          tmr_load = 1'b1;
          tmr_span = STB_T;
        end
      end
      ST_LD_PULSE, ST_CLR_PULSE: begin
        if (tmr_expired) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bits_left <= '0;
      byte_q    <= 1'b0;
      auto_q    <= 1'b0;
      ser_clk   <= 1'b1;
      ser_dat   <= 1'b0;
      sel_n     <= 1'b1;
      load_n    <= 1'b1;
      clr_n     <= 1'b1;
      clr_level <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      st <= nxt;
      if (shr_load) begin
        bits_left <= BIT_W'(FRAME_W);
        byte_q    <= byte_mode;
        auto_q    <= auto_load;
      end else if (shr_shift) begin
        bits_left <= bits_left - 1'b1;
      end
      if (shr_shift) ser_dat <= shr_msb;
      if (take_clear) clr_level <= clear_to_mid;
      ser_clk <= (nxt != ST_LOW);
      sel_n   <= !(nxt inside {ST_SETUP, ST_LOW, ST_HIGH, ST_GAP, ST_HOLD});
      load_n  <= (nxt != ST_LD_PULSE);
      clr_n   <= (nxt != ST_CLR_PULSE);
      busy    <= (nxt != ST_IDLE);
      done    <= (nxt == ST_IDLE) && ((st == ST_LD_PULSE) || (st == ST_CLR_PULSE));
    end
  end

endmodule

// File: rtl/dacq_frame_tx.sv
// Host-side sender for a quad 12-bit serial DAC: frame, load and clear strobes.
module dacq_frame_tx
  import dacq_tx_pkg::*;
#(
  parameter int CLK_PS        = 8000,    // system clock period
  parameter int SCLK_MAX_KHZ  = 30000,   // serial clock ceiling
  parameter int SCLK_PHASE_PS = 13000,   // minimum high and low phase
  parameter int SEL_GUARD_PS  = 13000,   // select setup and hold
  parameter int STROBE_PS     = 20000,   // load delay, load and clear widths
  parameter int GAP_CYC       = 4,       // parked-high cycles between halves
  parameter int ADDR_W        = 2,
  parameter int PAD_W         = 2,
  parameter int CODE_W        = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] chan_addr,
  input  logic [CODE_W-1:0] code,
  input  logic              byte_mode,
  input  logic              auto_load,
  input  logic              load_req,
  input  logic              clear_req,
  input  logic              clear_to_mid,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              sel_n,
  output logic              load_n,
  output logic              clr_n,
  output logic              clr_level,
  output logic              busy,
  output logic              done
);

  localparam int FRAME_W     = ADDR_W + PAD_W + CODE_W;
  localparam int SCLK_PER_PS = ceil_div(1_000_000_000, SCLK_MAX_KHZ);
  localparam int HALF_CYC    = max2(1, max2(ceil_div(SCLK_PHASE_PS, CLK_PS),
                                            ceil_div(ceil_div(SCLK_PER_PS, 2), CLK_PS)));
  localparam int SEL_CYC     = max2(1, ceil_div(SEL_GUARD_PS, CLK_PS));
  localparam int STB_CYC     = max2(1, ceil_div(STROBE_PS, CLK_PS));
  localparam int GAP_LEN     = max2(1, GAP_CYC);
  localparam int TMR_MAX     = max2(max2(HALF_CYC, SEL_CYC), max2(STB_CYC, GAP_LEN));
  localparam int TMR_W       = $clog2(TMR_MAX + 1);
  localparam int BIT_W       = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_word;
  logic               tmr_load, tmr_expired;
  logic [TMR_W-1:0]   tmr_span;
  logic               shr_load, shr_shift, shr_msb;

  assign frame_word = {chan_addr, {PAD_W{1'b0}}, code};

  dacq_span_timer #(.W(TMR_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .span    (tmr_span),
    .expired (tmr_expired)
  );

  dacq_frame_shreg #(.W(FRAME_W)) shreg_i (
    .clk   (clk),
    .rst   (rst),
    .load  (shr_load),
    .frame (frame_word),
    .shift (shr_shift),
    .msb   (shr_msb)
  );

  dacq_tx_seq #(
    .FRAME_W  (FRAME_W),
    .HALF_CYC (HALF_CYC),
    .SEL_CYC  (SEL_CYC),
    .STB_CYC  (STB_CYC),
    .GAP_LEN  (GAP_LEN),
    .TMR_W    (TMR_W),
    .BIT_W    (BIT_W)
  ) seq_i (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .byte_mode    (byte_mode),
    .auto_load    (auto_load),
    .load_req     (load_req),
    .clear_req    (clear_req),
    .clear_to_mid (clear_to_mid),
    .tmr_expired  (tmr_expired),
    .tmr_load     (tmr_load),
    .tmr_span     (tmr_span),
    .shr_load     (shr_load),
    .shr_shift    (shr_shift),
    .shr_msb      (shr_msb),
    .ser_clk      (ser_clk),
    .ser_dat      (ser_dat),
    .sel_n        (sel_n),
    .load_n       (load_n),
    .clr_n        (clr_n),
    .clr_level    (clr_level),
    .busy         (busy),
    .done         (done)
  );

endmodule

// File: rtl/dacq_tx_chk.sv
// Protocol checker attached to the sender's ports.
module dacq_tx_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic ser_clk,
  input logic ser_dat,
  input logic sel_n,
  input logic load_n,
  input logic clr_n,
  input logic clr_level,
  input logic busy,
  input logic done
);

  p_data_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !$past(sel_n) && (ser_dat != $past(ser_dat))) |-> $fell(ser_clk));

  p_clk_parked_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_n != $past(sel_n)) |-> (ser_clk && $past(ser_clk)));

  p_load_after_desel_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(load_n) |-> (sel_n && $past(sel_n)));

  p_clr_level_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr_n && !$past(clr_n)) |-> $stable(clr_level));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && load_n && clr_n));

  p_strobe_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (!load_n || !clr_n) |-> busy);

  p_start_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_no_load_in_frame_r11: assert property (@(posedge clk) disable iff (rst)
    !sel_n |-> load_n);

endmodule

bind dacq_frame_tx dacq_tx_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .ser_clk   (ser_clk),
  .ser_dat   (ser_dat),
  .sel_n     (sel_n),
  .load_n    (load_n),
  .clr_n     (clr_n),
  .clr_level (clr_level),
  .busy      (busy),
  .done      (done)
);

// File: tb/dacq_frame_tx_tb_top.sv
`timescale 1ns/1ps
module dacq_frame_tx_tb_top;

  // minimums in 8 ns cycles, rounded up from the ns figures
  localparam int PH_MIN  = 2;  // 13 ns phase
  localparam int PER_MIN = 5;  // 33.4 ns period
  localparam int SEL_MIN = 2;  // 13 ns select guard
  localparam int STB_MIN = 3;  // 20 ns strobe and delay
  localparam int GAP_MIN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, byte_mode = 0, auto_load = 0, load_req = 0, clear_req = 0, clear_to_mid = 0;
  logic [1:0]  chan_addr = '0;
  logic [11:0] code = '0;
  logic ser_clk, ser_dat, sel_n, load_n, clr_n, clr_level, busy, done;

  always #4 clk = ~clk;

  dacq_frame_tx dut_i (
    .clk(clk), .rst(rst), .start(start), .chan_addr(chan_addr), .code(code),
    .byte_mode(byte_mode), .auto_load(auto_load), .load_req(load_req),
    .clear_req(clear_req), .clear_to_mid(clear_to_mid),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .sel_n(sel_n), .load_n(load_n),
    .clr_n(clr_n), .clr_level(clr_level), .busy(busy), .done(done)
  );

  int nchk = 0, nfail = 0;
  int viol = 0;
  string vtag = "none";

  // line monitor state
  logic p_sclk, p_dat, p_sel, p_load, p_clr, p_cs, p_done;
  int run, since_rise, since_self, since_selr, since_cs, lo_l, lo_c;
  int bits, frames, loads, clears, mid_hi, last_bits;
  logic [15:0] capw, last_word;
  logic clr_at;

  task automatic flag(input string s);
    viol++;
    vtag = s;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      p_sclk = ser_clk; p_dat = ser_dat; p_sel = sel_n; p_load = load_n;
      p_clr = clr_n; p_cs = clr_level; p_done = done;
      run = 1; since_rise = 100; since_self = 100; since_selr = 100; since_cs = 100;
      lo_l = 0; lo_c = 0; bits = 0; capw = '0;
    end else begin
      since_rise++; since_self++; since_selr++; since_cs++;
      if (sel_n != p_sel) begin
        if (!(ser_clk && p_sclk)) flag("R4 clock not parked at select edge");
        if (!sel_n) begin
          bits = 0; capw = '0; since_self = 0;
        end else begin
          if (since_rise < SEL_MIN) flag("R5 select hold short");
          last_word = capw; last_bits = bits; frames++; since_selr = 0;
        end
      end
      if (!sel_n && !p_sel) begin
        if (ser_clk && !p_sclk) begin
          if (ser_dat != p_dat) flag("R3 data moved at rising edge");
          if (run < PH_MIN) flag("R5 low phase short");
          if (bits > 0 && since_rise < PER_MIN) flag("R5 clock period short");
          bits++; capw = {capw[14:0], ser_dat}; since_rise = 0;
        end else if (!ser_clk && p_sclk) begin
          if (bits == 0 && since_self < SEL_MIN) flag("R5 select setup short");
          if (bits > 0 && run < PH_MIN) flag("R5 high phase short");
          if (bits == 8) mid_hi = run;
        end else if (ser_dat != p_dat) begin
          flag("R3 data moved without clock fall");
        end
      end
      if (ser_clk != p_sclk) run = 1; else run++;
      if (clr_level != p_cs) since_cs = 0;
      // load strobe
      if (!load_n && p_load) begin
        if (!sel_n || since_selr < STB_MIN) flag("R7 load delay short");
        loads++; lo_l = 0;
      end
      if (!load_n) lo_l++;
      if (load_n && !p_load && lo_l < STB_MIN) flag("R7 load width short");
      // clear strobe
      if (!clr_n && p_clr) begin
        if (since_cs < STB_MIN) flag("R9 clear level set late");
        clears++; lo_c = 0; clr_at = clr_level;
      end
      if (!clr_n) begin
        lo_c++;
        if (!sel_n) flag("R9 select low during clear");
        if (!p_clr && clr_level != p_cs) flag("R9 clear level moved during pulse");
      end
      if (clr_n && !p_clr && lo_c < STB_MIN) flag("R9 clear width short");
      if (done) begin
        if (p_done) flag("R10 done longer than one cycle");
        if (busy || !load_n || !clr_n) flag("R10 done before idle");
      end
      if (!load_n && !sel_n) flag("R11 load during frame");
      p_sclk = ser_clk; p_dat = ser_dat; p_sel = sel_n; p_load = load_n;
      p_clr = clr_n; p_cs = clr_level; p_done = done;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic viol_chk(input string req);
    chk(viol == 0, req, {"line rules: ", vtag}, viol, 0);
    viol = 0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [1:0] a, input logic [11:0] c, input logic bm, input logic al);
    @(negedge clk);
    chan_addr = a; code = c; byte_mode = bm; auto_load = al; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (5) @(negedge clk);
    chk(ser_clk == 1 && sel_n == 1, "R1", "clock/select at reset", {ser_clk, sel_n}, 2'b11);
    rst = 0;
    @(negedge clk);
    chk(ser_clk == 1, "R1", "ser_clk idle", ser_clk, 1);
    chk(sel_n == 1, "R1", "sel_n idle", sel_n, 1);
    chk(load_n == 1 && clr_n == 1, "R1", "strobes idle", {load_n, clr_n}, 2'b11);
    chk(busy == 0 && done == 0, "R1", "busy/done idle", {busy, done}, 0);
    chk(clr_level == 0, "R1", "clear level", clr_level, 0);
  endtask

  task automatic t_frame(input logic [1:0] a, input logic [11:0] c, input logic bm);
    int f0, l0;
    bit seen;
    logic [15:0] exp;
    exp = {a, 2'b00, c};
    f0 = frames; l0 = loads;
    pulse_start(a, c, bm, 1'b1);
    chk(busy == 1, "R10", "busy after start", busy, 1);
    wait_done(seen);
    chk(seen, "R10", "done pulse seen", seen, 1);
    chk(frames == f0 + 1 && last_bits == 16, "R2", "rising edges per frame", last_bits, 16);
    chk(last_word == exp, "R2", "captured word", last_word, exp);
    chk(loads == l0 + 1, "R7", "auto load strobes", loads - l0, 1);
    if (bm) chk(mid_hi >= PH_MIN + GAP_MIN, "R6", "high run after bit 8", mid_hi, PH_MIN + GAP_MIN);
    viol_chk(bm ? "R6" : "R3");
  endtask

  task automatic t_manual();
    int f0, l0;
    bit seen;
    bit quiet;
    f0 = frames; l0 = loads;
    pulse_start(2'd1, 12'h5A3, 1'b0, 1'b0);
    for (int i = 0; i < 3000 && frames == f0; i++) @(negedge clk);
    quiet = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!load_n || !busy || done) quiet = 0;
    end
    chk(quiet, "R8", "waiting without load request", quiet, 1);
    chk(loads == l0, "R8", "no strobe before request", loads - l0, 0);
    @(negedge clk); load_req = 1;
    @(negedge clk); load_req = 0;
    wait_done(seen);
    chk(seen && loads == l0 + 1, "R8", "strobe after request", loads - l0, 1);
    chk(last_word == 16'h45A3, "R2", "manual frame word", last_word, 16'h45A3);
    viol_chk("R8");
  endtask

  task automatic t_ignore();
    int f0, c0;
    bit seen;
    f0 = frames; c0 = clears;
    pulse_start(2'd3, 12'h1E7, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chan_addr = 2'd0; code = 12'hABC; start = 1; clear_req = 1; clear_to_mid = 1;
    @(negedge clk);
    start = 0; clear_req = 0;
    wait_done(seen);
    repeat (20) @(negedge clk);
    chk(frames == f0 + 1, "R11", "frames after mid-frame start", frames - f0, 1);
    chk(last_word == 16'hC1E7, "R11", "word unchanged by late start", last_word, 16'hC1E7);
    chk(clears == c0 && busy == 0, "R11", "late clear ignored", clears - c0, 0);
    viol_chk("R11");
  endtask

  task automatic t_clear(input logic mid);
    int c0, f0, l0;
    bit seen;
    c0 = clears; f0 = frames; l0 = loads;
    @(negedge clk); clear_to_mid = mid; clear_req = 1;
    @(negedge clk); clear_req = 0;
    chk(busy == 1, "R10", "busy after clear request", busy, 1);
    wait_done(seen);
    chk(seen && clears == c0 + 1, "R9", "clear strobes", clears - c0, 1);
    chk(clr_at == mid, "R9", "clear level during pulse", clr_at, mid);
    chk(frames == f0 && loads == l0, "R9", "no frame or load on clear", frames - f0 + loads - l0, 0);
    viol_chk("R9");
  endtask

  initial begin
    frames = 0; loads = 0; clears = 0; mid_hi = 0; last_bits = 0; last_word = '0; clr_at = 0;
    t_reset();
    t_frame(2'd0, 12'hFFF, 1'b0);
    t_frame(2'd1, 12'h000, 1'b0);
    t_frame(2'd2, 12'hA5C, 1'b0);
    t_frame(2'd3, 12'h800, 1'b0);
    t_frame(2'd2, 12'h3C5, 1'b1);
    t_manual();
    t_ignore();
    t_clear(1'b1);
    t_clear(1'b0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule